// File: doc/BRIEF.md
# Burst Address Sequencer with Boundary Guard

This block holds the running byte address of a bus slave while it serves single, 32-bit block (BLT) and 64-bit multiplexed block (MBLT) transfers. The first address phase loads the full address. The second address phase, used by the double-edge protocols, rewrites only the low byte. In a block mode, every completed local data word steps the address by one 4-byte word. Only the field from bit 2 to bit 10 counts. Bits 1:0 and everything above bit 10 stay as loaded.

A burst may not run past its boundary: 256 bytes for BLT and 2048 bytes for MBLT. When a word is completed at the last word before that boundary, the block sets a sticky boundary flag. While the flag is set, a start request opens no local bus cycle. The request still clears the done flag, so the surrounding handshake keeps moving. The flag stays set until the next first-phase load or a reset.

Top module: `blkxfer_addr_seq`

## Requirements
- R1: After a synchronous active-high reset, the boundary flag, the done flag and the launch qualifier are all 0.
- R2: A first-phase load sets the address to {bus bits 31:1, long-word select in bit 0} on the next edge and clears the boundary flag.
- R3: A second-phase load with no first-phase load replaces address bits 7:0 with {bus bits 7:1, long-word select}. Bits 31:8 are unchanged.
- R4: A word-complete strobe in a block mode adds 1 to address bits 10:2, wrapping within that field. Bits 31:11 and 1:0 are unchanged.
- R5: The mode field is 2 bits: 00 = single, 01 = BLT, 10 = MBLT, and 11 behaves as single. In single mode, a word-complete strobe changes neither the address nor the boundary flag.
- R6: In BLT mode, a word completed while address bits 7:2 are all ones sets the boundary flag.
- R7: In MBLT mode, the boundary flag is set only when bits 10:2 are all ones at the word completion.
- R8: The launch qualifier is 1 in the cycle after a start request if and only if the boundary flag was 0 when the request was sampled.
- R9: A start request clears the done flag even when no cycle is launched. A word-complete strobe sets the done flag. When both arrive in the same cycle, the set wins.
- R10: Once set, the boundary flag stays set until a first-phase load or reset.
- R11: A load in the same cycle as a word-complete strobe takes priority. The address does not step and the boundary flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_ph1_i | input | 1 | First address phase load strobe |
| ld_ph2_i | input | 1 | Second address phase load strobe (low byte) |
| bus_addr_i | input | ADDR_W-1 | Bus address bits ADDR_W-1:1 |
| lword_n_i | input | 1 | Long-word select, stored in address bit 0 |
| mode_i | input | 2 | Transfer mode: 00 single, 01 BLT, 10 MBLT, 11 single |
| word_done_i | input | 1 | Local data word completed |
| start_i | input | 1 | Request to start the next local cycle |
| addr_o | output | ADDR_W | Current byte address |
| launch_o | output | 1 | Local cycle launched (registered) |
| bound_o | output | 1 | Sticky boundary flag |
| done_o | output | 1 | Done flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a start request and a set boundary flag: the launch must be withheld while the done flag still clears. The second pair is a word completion that meets a load: the load must win, and no flag may be set. Directed bursts from byte offsets 0xF8 and 0xFC in BLT mode, and from 0x7F8 in MBLT mode, issue more start requests than the boundary allows. They are judged by the count of launch pulses and by the final address. Random sequences overlap loads, strobes and requests freely, and a bench model that follows the requirements judges every cycle.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
  typedef enum logic [1:0] {
    XM_SINGLE = 2'b00,
    XM_BLT    = 2'b01,
    XM_MBLT   = 2'b10,
    XM_RSVD   = 2'b11
  } xfer_mode_e;

  function automatic logic is_block(input logic [1:0] m);
    return (m == XM_BLT) || (m == XM_MBLT);
  endfunction
endpackage

// File: rtl/bxs_addr_path.sv
module bxs_addr_path #(
  parameter int ADDR_W    = 32,
  parameter int WORD_LOG2 = 2,
  parameter int TOP_BIT   = 10,
  parameter int LOW_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld1,
  input  logic              ld2,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic              lword_n,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr
);
  localparam int FLD_W = TOP_BIT - WORD_LOG2 + 1;

  logic [ADDR_W-1:0] addr_q;
  logic [FLD_W-1:0]  fld_next;

  assign fld_next = addr_q[TOP_BIT:WORD_LOG2] + FLD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (ld1) begin
      addr_q <= {bus_addr, lword_n};
    end else if (ld2) begin
      addr_q[LOW_W-1:0] <= {bus_addr[LOW_W-1:1], lword_n};
    end else if (adv) begin
      addr_q[TOP_BIT:WORD_LOG2] <= fld_next;
    end
  end

  assign addr = addr_q;

  p_ph1_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld1 |=> addr_q == {$past(bus_addr), $past(lword_n)});
  p_ph2_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (ld2 && !ld1) |=> $stable(addr_q[ADDR_W-1:LOW_W]));
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    adv |=> addr_q[TOP_BIT:WORD_LOG2] == FLD_W'($past(addr_q[TOP_BIT:WORD_LOG2]) + 1));
  p_outside_r4: assert property (@(posedge clk) disable iff (rst)
    adv |=> ($stable(addr_q[ADDR_W-1:TOP_BIT+1]) && $stable(addr_q[WORD_LOG2-1:0])));
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld1 && !ld2 && !adv) |=> $stable(addr_q));
endmodule

// File: rtl/bxs_guard.sv
module bxs_guard #(
  parameter int ADDR_W    = 32,
  parameter int WORD_LOG2 = 2,
  parameter int BLT_LOG2  = 8,
  parameter int MBLT_LOG2 = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld1,
  input  logic              adv,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              bound
);
  import bxs_pkg::*;

  logic bound_q;
  logic blt_edge, mblt_edge, hit;

  assign blt_edge  = &addr[BLT_LOG2-1:WORD_LOG2];
  assign mblt_edge = blt_edge && (&addr[MBLT_LOG2-1:BLT_LOG2]);
  assign hit = (mode == XM_BLT) ? blt_edge :
               (mode == XM_MBLT) ? mblt_edge : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bound_q <= 1'b0;
    end else if (ld1) begin
      bound_q <= 1'b0;
    end else if (adv && hit) begin
      bound_q <= 1'b1;
    end
  end

  assign bound = bound_q;

  p_clear_on_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld1 |=> !bound_q);
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (bound_q && !ld1) |=> bound_q);
  p_single_no_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (!bound_q && !is_block(mode)) |=> !bound_q);
  p_mblt_span_r7: assert property (@(posedge clk) disable iff (rst)
    (!bound_q && mode == XM_MBLT && !(&addr[MBLT_LOG2-1:WORD_LOG2])) |=> !bound_q);
endmodule

// File: rtl/bxs_launch.sv
module bxs_launch (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic word_done,
  input  logic bound,
  output logic launch,
  output logic done
);
  logic launch_q, done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      launch_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      launch_q <= start && !bound;
      if (word_done) begin
        done_q <= 1'b1;
      end else if (start) begin
        done_q <= 1'b0;
      end
    end
  end

  assign launch = launch_q;
  assign done   = done_q;

  p_suppress_r8: assert property (@(posedge clk) disable iff (rst)
    bound |=> !launch_q);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> !launch_q);
  p_done_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !word_done) |=> !done_q);
  p_done_set_r9: assert property (@(posedge clk) disable iff (rst)
    word_done |=> done_q);
endmodule

// File: rtl/blkxfer_addr_seq.sv
module blkxfer_addr_seq #(
  parameter int ADDR_W    = 32,
  parameter int WORD_LOG2 = 2,
  parameter int BLT_LOG2  = 8,
  parameter int MBLT_LOG2 = 11,
  parameter int LOW_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_ph1_i,
  input  logic              ld_ph2_i,
  input  logic [ADDR_W-1:1] bus_addr_i,
  input  logic              lword_n_i,
  input  logic [1:0]        mode_i,
  input  logic              word_done_i,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              launch_o,
  output logic              bound_o,
  output logic              done_o
);
  import bxs_pkg::*;

  localparam int TOP_BIT = MBLT_LOG2 - 1;

  logic adv;
  logic [ADDR_W-1:0] addr_w;
  logic bound_w;

  assign adv = word_done_i && is_block(mode_i) && !ld_ph1_i && !ld_ph2_i;

  bxs_addr_path #(
    .ADDR_W(ADDR_W), .WORD_LOG2(WORD_LOG2), .TOP_BIT(TOP_BIT), .LOW_W(LOW_W)
  ) u_addr (
    .clk(clk), .rst(rst), .ld1(ld_ph1_i), .ld2(ld_ph2_i),
    .bus_addr(bus_addr_i), .lword_n(lword_n_i), .adv(adv), .addr(addr_w)
  );

  bxs_guard #(
    .ADDR_W(ADDR_W), .WORD_LOG2(WORD_LOG2), .BLT_LOG2(BLT_LOG2), .MBLT_LOG2(MBLT_LOG2)
  ) u_guard (
    .clk(clk), .rst(rst), .ld1(ld_ph1_i), .adv(adv), .mode(mode_i),
    .addr(addr_w), .bound(bound_w)
  );

  bxs_launch u_launch (
    .clk(clk), .rst(rst), .start(start_i), .word_done(word_done_i),
    .bound(bound_w), .launch(launch_o), .done(done_o)
  );

  assign addr_o  = addr_w;
  assign bound_o = bound_w;

  p_load_beats_step_r11: assert property (@(posedge clk) disable iff (rst)
    (ld_ph1_i && word_done_i) |=> !bound_w);
endmodule

// File: tb/tb_blkxfer_addr_seq.sv
module tb_blkxfer_addr_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld1 = 0, ld2 = 0, lw = 0, wd = 0, st = 0;
  logic [31:1] bus = '0;
  logic [1:0] mode = 2'b00;
  logic [31:0] addr;
  logic launch, bound, done;

  int checks = 0, fails = 0;
  logic [31:0] m_addr;
  logic m_bound, m_done, m_launch;

  always #2 clk = ~clk;

  blkxfer_addr_seq dut (
    .clk(clk), .rst(rst), .ld_ph1_i(ld1), .ld_ph2_i(ld2), .bus_addr_i(bus),
    .lword_n_i(lw), .mode_i(mode), .word_done_i(wd), .start_i(st),
    .addr_o(addr), .launch_o(launch), .bound_o(bound), .done_o(done)
  );

  function automatic logic blk(input logic [1:0] m);
    return m == 2'b01 || m == 2'b10;
  endfunction

  function automatic logic edge_hit(input logic [31:0] a, input logic [1:0] m);
    if (m == 2'b01) return a[7:2] == 6'h3F;
    if (m == 2'b10) return a[10:2] == 9'h1FF;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic l1, input logic l2, input logic [31:1] b, input logic l,
                      input logic [1:0] md, input logic w, input logic s);
    logic advance;
    string atag, btag;
    @(negedge clk);
    ld1 = l1; ld2 = l2; bus = b; lw = l; mode = md; wd = w; st = s;
    @(posedge clk);
    advance = w && blk(md) && !l1 && !l2;
    atag = l1 ? "R2" : l2 ? "R3" : advance ? "R4" : (w ? "R5" : "R11");
    btag = l1 ? "R2" : (advance && edge_hit(m_addr, md)) ? (md == 2'b01 ? "R6" : "R7") : "R10";
    if (w && (l1 || l2)) begin atag = "R11"; btag = "R11"; end
    m_launch = s && !m_bound;
    if (w) m_done = 1'b1; else if (s) m_done = 1'b0;
    if (l1) m_bound = 1'b0;
    else if (advance && edge_hit(m_addr, md)) m_bound = 1'b1;
    if (l1) m_addr = {b, l};
    else if (l2) m_addr[7:0] = {b[7:1], l};
    else if (advance) m_addr[10:2] = m_addr[10:2] + 9'd1;
    #1;
    chk(atag, addr, m_addr);
    chk(btag, {31'd0, bound}, {31'd0, m_bound});
    chk("R8", {31'd0, launch}, {31'd0, m_launch});
    chk("R9", {31'd0, done}, {31'd0, m_done});
  endtask

  task automatic burst(input logic [31:0] base, input logic [1:0] md, input int tries,
                       input int exp_n, input logic [31:0] exp_addr, input string tag);
    int n = 0;
    step(1, 0, base[31:1], base[0], md, 0, 0);
    for (int i = 0; i < tries; i++) begin
      step(0, 0, '0, 0, md, 0, 1);
      if (launch) begin
        n++;
        step(0, 0, '0, 0, md, 1, 0);
      end
    end
    chk({tag, " launches"}, n, exp_n);
    chk({tag, " addr"}, addr, exp_addr);
    chk("R10", {31'd0, bound}, 32'd1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {29'd0, bound, done, launch}, 32'd0);
    rst = 1'b0;
    m_addr = '0; m_bound = 0; m_done = 0; m_launch = 0;

    // R6: BLT from 0xF8 allows two words; from 0xFC one word
    burst(32'hA000_00F8, 2'b01, 4, 2, 32'hA000_0100, "R6");
    burst(32'hA000_00FC, 2'b01, 3, 1, 32'hA000_0100, "R6");
    // R7: MBLT from 0x7F8 wraps field only, bit 11 kept
    burst(32'h1234_57F8, 2'b10, 4, 2, 32'h1234_5000, "R7");
    // R7: MBLT crosses a 256-byte line without flag
    step(1, 0, 31'h0000_00FC >> 1, 0, 2'b10, 0, 0);
    step(0, 0, '0, 0, 2'b10, 1, 0);
    chk("R7", {31'd0, bound}, 32'd0);
    // R9: suppressed start still clears done (flag set first)
    step(1, 0, 31'h7E, 0, 2'b01, 0, 0);
    step(0, 0, '0, 0, 2'b01, 1, 0);
    step(0, 0, '0, 0, 2'b01, 0, 1);
    chk("R9", {30'd0, launch, done}, 32'd0);
    // R5: mode 11 acts as single
    step(1, 0, 31'h7FFF_FFFF, 1, 2'b11, 0, 0);
    step(0, 0, '0, 0, 2'b11, 1, 0);
    chk("R5", addr, 32'hFFFF_FFFF);
    // R11: load meets word completion at the edge
    step(1, 0, 31'h7E, 0, 2'b01, 0, 0);
    step(0, 1, 31'h7E, 0, 2'b01, 1, 0);
    chk("R11", {31'd0, bound}, 32'd0);
    // R3: second phase only low byte
    step(1, 0, 31'h7654_3210, 0, 2'b00, 0, 0);
    step(0, 1, 31'h0000_0055, 1, 2'b00, 0, 0);
    chk("R3", addr, 32'hECA8_64AB);

    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[2:0] == 0), (r[6:3] == 0), {$urandom} >> 1, r[7], r[9:8], r[10], r[11]);
    end

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", {29'd0, bound, done, launch}, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule